// File: doc/BRIEF.md
# Tile Cycle Sequencer

This block paces a three-stage overlapped pipeline that processes a picture one square tile at a time. In every tile cycle, one tile of pixels is being fetched, the tile before it is being computed, and the tile before that is being stored, all at once. The sequencer provides the element index and the phase signals that let a surrounding datapath do this. The datapath itself is not part of this block.

A tile cycle starts with a main phase in which an element index steps through every position of the tile, one per clock. Three single-clock phases follow:
- transfer: the fetched tile moves into the compute registers and the compute cells capture their sums;
- latch: the results move into the store registers;
- decide: the `last_tile` input is sampled.

The post-count phases come from a chain of three flip-flops, not from an encoded state register. When a cycle ends with `last_tile` low, the counter reloads and the chain clears itself stage by stage while the next main phase is already counting. When a cycle ends with `last_tile` high, the sequencer stops and holds `done`.

Holding `cfg_mode` high is the configuration state. Releasing it starts the first cycle.

Top module: `tile_seq`

## Requirements
- R1: While `rst` or `cfg_mode` is high, every output is 0 (`idx` = 0). In the clock after either one is released, `run` = 1 and `idx` = 0.
- R2: During the main phase, `run` = 1 and `idx` counts up by one per clock from 0 to 2^IDX_W−1 (63 by default).
- R3: In the clock after `idx` reaches 63, `xfer_stb` is high for exactly one clock while `run` is low.
- R4: `latch_stb` is high for exactly the one clock after `xfer_stb`.
- R5: `decide` is high for exactly the one clock after `latch_stb`. `last_tile` has no effect on any output in any other clock.
- R6: If `last_tile` is 0 during `decide`, the next clock has `run` = 1 and `idx` = 0. A tile cycle therefore lasts exactly 2^IDX_W+3 (67) clocks.
- R7: If `last_tile` is 1 during `decide`, then from the next clock `done` = 1, `run` = 0, `idx` = 0, and all strobes stay low.
- R8: `done` stays high until `cfg_mode` or `rst` is asserted.
- R9: At most one of `run`, `xfer_stb`, `latch_stb`, `decide` and `done` is high in any clock.
- R10: For a job of n tiles, `done` first reads high exactly 67·n clocks after the first main-phase clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 1 | Configuration state; high holds the sequencer idle and clears it |
| last_tile | input | 1 | Sampled during `decide`; high ends the job after this cycle |
| idx | output | IDX_W | Element index during the main phase, 0 otherwise |
| run | output | 1 | Main phase active |
| xfer_stb | output | 1 | Transfer phase: fetched tile to compute registers, compute cells capture sums |
| latch_stb | output | 1 | Latch phase: results to store registers |
| decide | output | 1 | Decide phase; `last_tile` is sampled |
| done | output | 1 | Job finished |

## Verification
Jobs of one to four tiles are run. Single-tile jobs exercise the finish path without any restart. Multi-tile jobs confirm that the restart keeps a 67-clock period while the chain is still clearing.

`last_tile` is driven randomly outside the decide clock, so any leak of it into the phase sequence shows up as a wrong index or a misplaced strobe. Two jobs are aborted partway through: one by `cfg_mode` and one by `rst`. These show that both inputs silence the outputs at once and restart cleanly from index 0.

// File: rtl/tile_seq_pkg.sv
package tile_seq_pkg;

    localparam int unsigned DEF_IDX_W = 6;
    localparam int unsigned POST_PHASES = 3;

    typedef struct packed {
        logic run;
        logic xfer;
        logic latch;
        logic decide;
        logic done;
    } seq_phase_t;

    function automatic int unsigned cycle_clocks(input int unsigned idx_w);
        return (32'd1 << idx_w) + POST_PHASES;
    endfunction

endpackage

// File: rtl/tile_seq_counter.sv
module tile_seq_counter #(
    parameter int unsigned IDX_W = tile_seq_pkg::DEF_IDX_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           restart,
    output logic [IDX_W:0] cnt,
    output logic           full
);
    // counts while the top bit is clear, parks once it sets
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (!cnt[IDX_W]) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign full = cnt[IDX_W];

endmodule

// File: rtl/tile_seq_chain.sv
module tile_seq_chain #(
    parameter int unsigned FOLLOW = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              full,
    input  logic              last_tile,
    output logic [FOLLOW-1:0] fol,
    output logic              ff_end,
    output logic              fin,
    output logic              dec,
    output logic              restart
);
    // Each stage sets when its predecessor is high and clears when it is low,
    // so the release after a restart ripples down the chain one clock per stage.
    for (genvar s = 0; s < FOLLOW; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                fol[s] <= 1'b0;
            end else if (s == 0) begin
                fol[s] <= full;
            end else begin
                fol[s] <= fol[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign dec     = fol[FOLLOW-1] & ~ff_end & ~fin;
    assign restart = dec & ~last_tile;

    // Final stage: set by a restart, cleared once the stage before it has released.
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ff_end <= 1'b0;
        end else if (restart) begin
            ff_end <= 1'b1;
        end else if (!fol[FOLLOW-1]) begin
            ff_end <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            fin <= 1'b0;
        end else if (dec && last_tile) begin
            fin <= 1'b1;
        end
    end

    a_r5_decide_single: assert property (@(posedge clk) disable iff (rst || clr)
        dec |=> !dec);

endmodule

// File: rtl/tile_seq.sv
module tile_seq #(
    parameter int unsigned IDX_W = tile_seq_pkg::DEF_IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_mode,
    input  logic             last_tile,
    output logic [IDX_W-1:0] idx,
    output logic             run,
    output logic             xfer_stb,
    output logic             latch_stb,
    output logic             decide,
    output logic             done
);
    import tile_seq_pkg::*;

    localparam int unsigned FOLLOW = POST_PHASES - 1;
    localparam logic [IDX_W-1:0] LAST_IDX = '1;

    logic [IDX_W:0]    cnt;
    logic              full;
    logic [FOLLOW-1:0] fol;
    logic              ff_end, fin, dec, restart, quiet;
    seq_phase_t        ph;

    tile_seq_counter #(.IDX_W(IDX_W)) u_cnt (
        .clk(clk), .rst(rst), .clr(cfg_mode), .restart(restart),
        .cnt(cnt), .full(full)
    );

    tile_seq_chain #(.FOLLOW(FOLLOW)) u_chain (
        .clk(clk), .rst(rst), .clr(cfg_mode), .full(full),
        .last_tile(last_tile), .fol(fol), .ff_end(ff_end),
        .fin(fin), .dec(dec), .restart(restart)
    );

    assign quiet = rst | cfg_mode;

    always_comb begin
        ph.run    = ~full & ~quiet;
        ph.xfer   = full & ~fol[0] & ~quiet;
        ph.latch  = fol[0] & ~fol[FOLLOW-1] & ~quiet;
        ph.decide = dec & ~quiet;
        ph.done   = fin & ~quiet;
    end

    assign run       = ph.run;
    assign xfer_stb  = ph.xfer;
    assign latch_stb = ph.latch;
    assign decide    = ph.decide;
    assign done      = ph.done;
    assign idx       = ph.run ? cnt[IDX_W-1:0] : '0;

    a_r2_index_step: assert property (@(posedge clk) disable iff (rst)
        (run && idx != LAST_IDX) |=> ((run && idx == $past(idx) + 1'b1) || cfg_mode));
    a_r3_xfer_after_count: assert property (@(posedge clk) disable iff (rst)
        (run && idx == LAST_IDX) |=> (xfer_stb || cfg_mode));
    a_r4_latch_after_xfer: assert property (@(posedge clk) disable iff (rst)
        xfer_stb |=> (latch_stb || cfg_mode));
    a_r5_decide_after_latch: assert property (@(posedge clk) disable iff (rst)
        latch_stb |=> (decide || cfg_mode));
    a_r6_restart: assert property (@(posedge clk) disable iff (rst)
        (decide && !last_tile) |=> ((run && idx == '0) || cfg_mode));
    a_r7_finish: assert property (@(posedge clk) disable iff (rst)
        (decide && last_tile) |=> (done || cfg_mode));
    a_r8_done_hold: assert property (@(posedge clk) disable iff (rst)
        done |=> (done || cfg_mode));
    a_r9_one_phase: assert property (@(posedge clk) disable iff (rst)
        $onehot0({run, xfer_stb, latch_stb, decide, done}));

endmodule

// File: tb/tile_seq_bench.sv
module tile_seq_bench;
    localparam int IDX_W = 6;
    localparam int TILE = 1 << IDX_W;
    localparam int CYC = TILE + 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_mode = 1'b0;
    logic last_tile = 1'b0;
    logic [IDX_W-1:0] idx;
    logic run, xfer_stb, latch_stb, decide, done;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    tile_seq #(.IDX_W(IDX_W)) u_tile_seq (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .last_tile(last_tile),
        .idx(idx), .run(run), .xfer_stb(xfer_stb), .latch_stb(latch_stb),
        .decide(decide), .done(done)
    );

    function automatic logic [10:0] expv(int p, bit fin);
        if (fin) return {5'b00001, 6'd0};
        if (p < TILE) return {5'b10000, 6'(p)};
        if (p == TILE) return {5'b01000, 6'd0};
        if (p == TILE + 1) return {5'b00100, 6'd0};
        return {5'b00010, 6'd0};
    endfunction

    function automatic logic [10:0] got();
        return {run, xfer_stb, latch_stb, decide, done, idx};
    endfunction

    task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic run_job(int n, int abort_at, bit abort_rst);
        int p = 0;
        int k = 0;
        bit fin = 0;
        int cyc = 0;
        int fin_cyc = 0;
        int done_at = -1;
        string tag;
        @(negedge clk);
        cfg_mode = 1'b1;
        last_tile = 1'b1;
        #1 chk(got() == 11'd0, "R1", 16'(got()), 16'd0);   // cfg silences immediately, done dropped (R8)
        @(negedge clk);
        #1 chk(got() == 11'd0, "R1", 16'(got()), 16'd0);
        @(negedge clk);
        cfg_mode = 1'b0;
        while (cyc < 2000) begin
            if (abort_at >= 0 && cyc == abort_at) begin
                if (abort_rst) rst = 1'b1; else cfg_mode = 1'b1;
                #1 chk(got() == 11'd0, "R1", 16'(got()), 16'd0);
                @(negedge clk);
                #1 chk(got() == 11'd0, "R1", 16'(got()), 16'd0);
                rst = 1'b0;
                cfg_mode = 1'b0;
                #1 chk(got() == {5'b10000, 6'd0}, "R1", 16'(got()), 16'({5'b10000, 6'd0}));
                return;
            end
            if (!fin && p == CYC - 1) last_tile = (k == n - 1);
            else last_tile = 1'($urandom % 2);   // R5: noise outside decide
            #1;
            if (fin) tag = "R8";
            else if (p == 0 && k > 0) tag = "R6";
            else if (p < TILE) tag = "R2";
            else if (p == TILE) tag = "R3";
            else if (p == TILE + 1) tag = "R4";
            else tag = "R5";
            chk(got() == expv(p, fin), tag, 16'(got()), 16'(expv(p, fin)));
            chk($countones({run, xfer_stb, latch_stb, decide, done}) <= 1, "R9",
                16'({run, xfer_stb, latch_stb, decide, done}), 16'd0);
            if (fin) begin
                fin_cyc++;
                if (fin_cyc == 1) chk(got() == {5'b00001, 6'd0}, "R7", 16'(got()), 16'({5'b00001, 6'd0}));
                if (fin_cyc >= 20) break;
            end
            @(posedge clk);
            cyc++;
            if (!fin) begin
                if (p == CYC - 1) begin
                    if (k == n - 1) begin
                        fin = 1;
                        done_at = cyc;
                    end else begin
                        p = 0;
                        k++;
                    end
                end else begin
                    p++;
                end
            end
            @(negedge clk);
        end
        chk(done_at == CYC * n, "R10", 16'(done_at), 16'(CYC * n));
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        #1 chk(got() == 11'd0, "R1", 16'(got()), 16'd0);
        rst = 1'b0;
        run_job(1, -1, 0);
        run_job(3, -1, 0);
        run_job(2, 100, 0);
        run_job(2, -1, 0);
        run_job(4, 150, 1);
        run_job(1 + int'($urandom % 4), -1, 0);
        run_job(1 + int'($urandom % 4), -1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule